// File: doc/BRIEF.md
# Shared Data Memory Controller with Buffered Streaming Agents

This block sits in front of an external synchronous SRAM and shares it among five requesters. Four streaming agents never touch the memory directly. Each agent posts word requests (address, plus data for writers) into its own queue. The queues drain one word per cycle whenever the host is idle, and they take turns in a round-robin order. The fifth requester, the host, bypasses the queues. A host request always takes the memory in the next cycle.

Each streaming lane has a fixed direction. Lane 0 and lane 3 only read. Lane 1 and lane 2 only write. The host can do both. The address space covers several equal banks. The bits above the per-bank width pick one chip select, and the lower bits go to the SRAM address pins.

An optional even parity bit is stored beside every word. When the parity bit is checked on a read, a mismatch raises a sticky error that records the failing address. Memory that was never freshly written holds mismatching parity, so the same check also catches reads of stale data, such as an underrun on a receive stream. Parity can be switched off so that memory without a parity bit can be used.

Top module: `bufarb_ctrl`

## Requirements
- R1: Reset state. While reset is applied and just after it, no chip select is active, every lane reports ready, no read-return valid is high, and the parity error flag is low.
- R2: Host priority. A host request sampled on a clock edge appears on the memory pins in the following cycle, with the host's lower address bits and read/write direction. No queued lane is served while the host keeps requesting.
- R3: Queue capacity. Each lane queue holds DEPTH words. A lane's ready output goes low once DEPTH words are waiting, and a request offered while ready is low is dropped. Draining the queue restores ready.
- R4: Write lanes. Lane 1 and lane 2 write their queued words to memory in the order they were accepted. Lane g takes its address from ag_addr[g*AW +: AW] and its data from ag_wdata[g*DW +: DW].
- R5: Read returns. Lane 0 and lane 3 get their read data on the shared ag_rdata bus, marked by ag_rvalid[g], in the order the requests were accepted. A host read returns on host_rdata with host_rvalid high exactly three clock edges after the request was sampled. At most one return valid is high in any cycle.
- R6: Round robin. When the host is idle, the non-empty lanes are served one word per cycle. The search starts at the lane after the last one served, and lane 0 comes first after reset. With all four lanes pending, the service order is 0,1,2,3,0,...
- R7: Bank select. The bank number is the address bits above BANK_AW. Exactly one of mem_cs is asserted for each access, and mem_addr carries the low BANK_AW bits.
- R8: Parity generation. When parity is enabled, each write also writes mem_wpar (mem_pwe high), set to the XOR of the data bits.
- R9: Error capture. When parity is enabled, a read whose stored parity bit differs from the XOR of its data bits sets par_err and records the full address in par_err_addr. The flag and address then hold until cleared. This applies to reads from any requester, including locations that were never freshly written.
- R10: Error clear. A one-cycle pulse on err_clr clears par_err in the next cycle.
- R11: Parity off. When parity_en is low, mem_pwe stays low so the stored parity bit is left unchanged. No parity error is raised even if the stored parity mismatches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| parity_en | input | 1 | Enables parity write and check |
| err_clr | input | 1 | Clears the sticky parity error |
| host_req | input | 1 | Host requests one word this cycle |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | AW | Host full address |
| host_wdata | input | DW | Host write data |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | DW | Host read data |
| ag_valid | input | 4 | Per-lane request valid |
| ag_ready | output | 4 | Per-lane queue not full |
| ag_addr | input | 4*AW | Per-lane request address, lane g at bits g*AW |
| ag_wdata | input | 4*DW | Per-lane write data, lane g at bits g*DW |
| ag_rvalid | output | 4 | Per-lane read return valid |
| ag_rdata | output | DW | Shared read return data |
| mem_cs | output | NUM_BANKS | One chip select per bank |
| mem_we | output | 1 | Memory write enable for data |
| mem_pwe | output | 1 | Memory write enable for parity bit |
| mem_addr | output | BANK_AW | Address within bank |
| mem_wdata | output | DW | Memory write data |
| mem_wpar | output | 1 | Memory write parity bit |
| mem_rdata | input | DW | Memory read data, one cycle after read |
| mem_rpar | input | 1 | Memory read parity bit |
| par_err | output | 1 | Sticky parity error |
| par_err_addr | output | AW | Address of the first failing read |

## Verification
The hardest state to reach from the ports is four queues that are all full at once, because queues drain as fast as they fill whenever the bus is free. The bench keeps the host issuing back-to-back reads so that nothing drains. It fills every lane to capacity, offers one extra word to each lane, and then releases the host. It then logs the exact order of memory accesses that follows. Parity faults come from the bench's SRAM model, which flips stored parity bits directly. This produces errors on both the host path and the read-lane path, and shows that the error flag keeps the first address it recorded.

// File: rtl/bufarb_pkg.sv
package bufarb_pkg;
    localparam int NAG = 4;
    // lanes 1 and 2 only write, lanes 0 and 3 only read
    localparam logic [NAG-1:0] AG_WRITES = 4'b0110;
    typedef enum logic [0:0] {SRC_LANE = 1'b0, SRC_HOST = 1'b1} src_e;
endpackage

// File: rtl/bufarb_fifo.sv
module bufarb_fifo #(
    parameter int W     = 40,
    parameter int DEPTH = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [PW:0]   cnt;
    } fst_t;

    fst_t s_d, s_q;
    logic [W-1:0] store [DEPTH];

    always_comb begin
        s_d = s_q;
        if (push) s_d.wr = s_q.wr + 1'b1;
        if (pop)  s_d.rd = s_q.rd + 1'b1;
        s_d.cnt = s_q.cnt + (PW+1)'(push) - (PW+1)'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) store[s_q.wr] <= din;
    end

    assign dout  = store[s_q.rd];
    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == (PW+1)'(DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/bufarb_rr.sv
module bufarb_rr #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic                 advance,
    output logic [$clog2(N)-1:0] gnt_idx,
    output logic                 any
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] ptr_d, ptr_q;
    logic [IW-1:0] pick;

    always_comb begin
        logic          found;
        logic [IW-1:0] cand;
        pick  = ptr_q;
        found = 1'b0;
        for (int off = 1; off <= N; off++) begin
            cand = IW'((int'(ptr_q) + off) % N);
            if (!found && req[cand]) begin
                pick  = cand;
                found = 1'b1;
            end
        end
        ptr_d = (advance && found) ? pick : ptr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= IW'(N-1);
        else        ptr_q <= ptr_d;
    end

    assign gnt_idx = pick;
    assign any     = |req;

    p_rotate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && (&req)) ##1 (advance && (&req))
        |-> gnt_idx == IW'((int'($past(gnt_idx)) + 1) % N));
endmodule

// File: rtl/bufarb_ctrl.sv
module bufarb_ctrl
    import bufarb_pkg::*;
#(
    parameter int DW        = 32,
    parameter int BANK_AW   = 16,
    parameter int NUM_BANKS = 4,
    parameter int DEPTH     = 128,
    localparam int BSW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int AW  = BANK_AW + ((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 0)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 parity_en,
    input  logic                 err_clr,
    input  logic                 host_req,
    input  logic                 host_we,
    input  logic [AW-1:0]        host_addr,
    input  logic [DW-1:0]        host_wdata,
    output logic                 host_rvalid,
    output logic [DW-1:0]        host_rdata,
    input  logic [NAG-1:0]       ag_valid,
    output logic [NAG-1:0]       ag_ready,
    input  logic [NAG*AW-1:0]    ag_addr,
    input  logic [NAG*DW-1:0]    ag_wdata,
    output logic [NAG-1:0]       ag_rvalid,
    output logic [DW-1:0]        ag_rdata,
    output logic [NUM_BANKS-1:0] mem_cs,
    output logic                 mem_we,
    output logic                 mem_pwe,
    output logic [BANK_AW-1:0]   mem_addr,
    output logic [DW-1:0]        mem_wdata,
    output logic                 mem_wpar,
    input  logic [DW-1:0]        mem_rdata,
    input  logic                 mem_rpar,
    output logic                 par_err,
    output logic [AW-1:0]        par_err_addr
);
    localparam int EW = AW + DW;
    localparam int IW = $clog2(NAG);

    typedef struct packed {
        logic          rd;
        src_e          src;
        logic [IW-1:0] idx;
        logic [AW-1:0] addr;
    } tag_t;

    typedef struct packed {
        logic [NUM_BANKS-1:0] cs;
        logic                 we;
        logic                 pwe;
        logic [BANK_AW-1:0]   maddr;
        logic [DW-1:0]        wdata;
        logic                 wpar;
        tag_t                 t1;
        tag_t                 t2;
        logic                 hrv;
        logic [NAG-1:0]       arv;
        logic [DW-1:0]        rdata;
        logic                 err;
        logic [AW-1:0]        eaddr;
    } st_t;

    st_t s_d, s_q;

    logic [NAG-1:0] q_empty, q_full, q_push, q_pop;
    logic [AW-1:0]  head_addr [NAG];
    logic [DW-1:0]  head_data [NAG];
    logic [IW-1:0]  arb_idx;
    logic           arb_any, arb_adv;

    assign q_push   = ag_valid & ~q_full;
    assign ag_ready = ~q_full;

    for (genvar g = 0; g < NAG; g++) begin : g_lane
        logic [EW-1:0] q_out;
        bufarb_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[g]),
            .din   ({ag_addr[g*AW +: AW], ag_wdata[g*DW +: DW]}),
            .pop   (q_pop[g]),
            .dout  (q_out),
            .empty (q_empty[g]),
            .full  (q_full[g])
        );
        assign head_addr[g] = q_out[EW-1 -: AW];
        assign head_data[g] = q_out[DW-1:0];
    end

    bufarb_rr #(.N(NAG)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (~q_empty),
        .advance (arb_adv),
        .gnt_idx (arb_idx),
        .any     (arb_any)
    );

    assign arb_adv = !host_req && arb_any;

    always_comb begin
        logic          go, we;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [BSW-1:0] bank;
        logic          mism;
        src_e          src;

        s_d   = s_q;
        q_pop = '0;
        go    = 1'b0;
        we    = 1'b0;
        a     = '0;
        d     = '0;
        src   = SRC_LANE;
        if (host_req) begin
            go  = 1'b1;
            we  = host_we;
            a   = host_addr;
            d   = host_wdata;
            src = SRC_HOST;
        end else if (arb_any) begin
            go  = 1'b1;
            we  = AG_WRITES[arb_idx];
            a   = head_addr[arb_idx];
            d   = head_data[arb_idx];
            q_pop[arb_idx] = 1'b1;
        end

        // command stage
        bank = BSW'(a >> BANK_AW);
        s_d.cs = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (go && bank == BSW'(b)) s_d.cs[b] = 1'b1;
        end
        s_d.we    = go && we;
        s_d.pwe   = go && we && parity_en;
        s_d.maddr = a[BANK_AW-1:0];
        s_d.wdata = d;
        s_d.wpar  = parity_en ? ^d : 1'b0;
        s_d.t1    = '{rd: go && !we, src: src, idx: arb_idx, addr: a};
        s_d.t2    = s_q.t1;

        // return stage
        s_d.hrv = s_q.t2.rd && (s_q.t2.src == SRC_HOST);
        s_d.arv = '0;
        if (s_q.t2.rd && s_q.t2.src == SRC_LANE) s_d.arv[s_q.t2.idx] = 1'b1;
        if (s_q.t2.rd) s_d.rdata = mem_rdata;

        mism = s_q.t2.rd && parity_en && ((^mem_rdata) != mem_rpar);
        s_d.err = s_q.err && !err_clr;
        if (mism && !s_d.err) begin
            s_d.err   = 1'b1;
            s_d.eaddr = s_q.t2.addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_cs       = s_q.cs;
    assign mem_we       = s_q.we;
    assign mem_pwe      = s_q.pwe;
    assign mem_addr     = s_q.maddr;
    assign mem_wdata    = s_q.wdata;
    assign mem_wpar     = s_q.wpar;
    assign host_rvalid  = s_q.hrv;
    assign host_rdata   = s_q.rdata;
    assign ag_rvalid    = s_q.arv;
    assign ag_rdata     = s_q.rdata;
    assign par_err      = s_q.err;
    assign par_err_addr = s_q.eaddr;

    p_host_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_req |=> (mem_addr == $past(host_addr[BANK_AW-1:0])) && (mem_we == $past(host_we)));
    p_one_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_cs));
    p_host_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid == $past(host_req && !host_we, 3));
    p_one_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_rvalid, ag_rvalid}));
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && !err_clr) |=> (par_err && $stable(par_err_addr)));
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !(s_q.t2.rd && parity_en)) |=> !par_err);
    p_no_pwe_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !parity_en |=> !mem_pwe);
    p_no_err_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!parity_en && !par_err) |=> !par_err);
endmodule

// File: tb/bufarb_ctrl_bench.sv
module bufarb_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 8;
    localparam int BAW = 4;
    localparam int NB  = 4;
    localparam int DEP = 4;
    localparam int AW  = 6;
    localparam int NW  = 64;

    logic clk = 1'b0;
    logic rst_n, parity_en, err_clr;
    logic host_req, host_we, host_rvalid;
    logic [AW-1:0] host_addr;
    logic [DW-1:0] host_wdata, host_rdata;
    logic [3:0] ag_valid, ag_ready, ag_rvalid;
    logic [4*AW-1:0] ag_addr;
    logic [4*DW-1:0] ag_wdata;
    logic [DW-1:0] ag_rdata;
    logic [NB-1:0] mem_cs;
    logic mem_we, mem_pwe, mem_wpar, mem_rpar;
    logic [BAW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic par_err;
    logic [AW-1:0] par_err_addr;

    int n_checks = 0;
    int n_fail   = 0;

    bufarb_ctrl #(.DW(DW), .BANK_AW(BAW), .NUM_BANKS(NB), .DEPTH(DEP)) u_bufarb_ctrl (
        .clk(clk), .rst_n(rst_n), .parity_en(parity_en), .err_clr(err_clr),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .ag_valid(ag_valid), .ag_ready(ag_ready), .ag_addr(ag_addr),
        .ag_wdata(ag_wdata), .ag_rvalid(ag_rvalid), .ag_rdata(ag_rdata),
        .mem_cs(mem_cs), .mem_we(mem_we), .mem_pwe(mem_pwe), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wpar(mem_wpar), .mem_rdata(mem_rdata),
        .mem_rpar(mem_rpar), .par_err(par_err), .par_err_addr(par_err_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // SRAM model with one-cycle read latency
    logic [DW-1:0] md [NW];
    logic          mp [NW];
    logic [DW-1:0] rd_q = '0;
    logic          rp_q = 1'b0;
    int  bad_cs = 0;
    logic logging = 1'b0;
    int  acc_log [32];
    int  n_log = 0;

    always @(posedge clk) begin
        int hits;
        int a;
        hits = 0;
        a = 0;
        for (int b = 0; b < NB; b++) begin
            if (mem_cs[b]) begin
                hits++;
                a = b * 16 + int'(mem_addr);
            end
        end
        if (hits > 1) bad_cs++;
        if (hits == 1) begin
            if (mem_we)  md[a] <= mem_wdata;
            if (mem_pwe) mp[a] <= mem_wpar;
            if (!mem_we) begin
                rd_q <= md[a];
                rp_q <= mp[a];
            end
            if (logging && a != 0 && n_log < 32) begin
                acc_log[n_log] = a;
                n_log++;
            end
        end
    end
    assign mem_rdata = rd_q;
    assign mem_rpar  = rp_q;

    // lane return capture
    logic [DW-1:0] rq [4][8];
    int rn [4] = '{0, 0, 0, 0};
    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (ag_rvalid[i] && rn[i] < 8) begin
                rq[i][rn[i]] = ag_rdata;
                rn[i]++;
            end
        end
    end

    function automatic logic [DW-1:0] f(int a);
        return DW'(a * 37 + 11);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [DW-1:0] d);
        host_req = 1'b1; host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_read(input int a, input logic [DW-1:0] exp, input string req);
        host_req = 1'b1; host_we = 1'b0; host_addr = AW'(a);
        @(negedge clk);
        host_req = 1'b0;
        @(negedge clk);
        chk(host_rvalid == 1'b0, req, int'(host_rvalid), 0);
        @(negedge clk);
        chk(host_rvalid == 1'b1, req, int'(host_rvalid), 1);
        chk(host_rdata == exp, req, int'(host_rdata), int'(exp));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; parity_en = 1'b1; err_clr = 1'b0;
        host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
        ag_valid = '0; ag_addr = '0; ag_wdata = '0;
        for (int a = 0; a < NW; a++) begin
            md[a] = '0;
            mp[a] = 1'b1;   // poisoned: mismatching parity
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_cs == '0, "R1 cs", int'(mem_cs), 0);
        chk(ag_ready == 4'hF, "R1 ready", int'(ag_ready), 15);
        chk({host_rvalid, ag_rvalid} == '0, "R1 rvalid", int'({host_rvalid, ag_rvalid}), 0);
        chk(par_err == 1'b0, "R1 err", int'(par_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_cs == '0 && ag_ready == 4'hF && !par_err, "R1 after release",
            int'({mem_cs, ag_ready}), 15);

        // R2 R7 R8: host writes to every address of every bank
        for (int a = 0; a < NW; a++) host_write(a, f(a));
        repeat (2) @(negedge clk);
        for (int a = 0; a < NW; a++) begin
            chk(md[a] == f(a), "R7 bank/data placement", int'(md[a]), int'(f(a)));
            chk(mp[a] == ^f(a), "R8 parity bit", int'(mp[a]), int'(^f(a)));
        end
        chk(bad_cs == 0, "R7 single chip select", bad_cs, 0);

        // R5: host reads, exact latency, no parity error
        for (int a = 0; a < NW; a++) host_read(a, f(a), "R5 host read");
        chk(par_err == 1'b0, "R9 no error on good data", int'(par_err), 0);

        // R2 R3 R6: park host on bus, fill all queues, then release
        host_req = 1'b1; host_we = 1'b0; host_addr = '0;
        @(negedge clk);
        for (int k = 0; k < DEP; k++) begin
            ag_valid = 4'hF;
            for (int i = 0; i < 4; i++) begin
                ag_addr[i*AW +: AW]  = AW'(i * 16 + k + 1);
                ag_wdata[i*DW +: DW] = DW'(8'h40 + i * 8 + k);
            end
            @(negedge clk);
        end
        chk(ag_ready == 4'h0, "R3 ready low when full", int'(ag_ready), 0);
        for (int i = 0; i < 4; i++) begin
            ag_addr[i*AW +: AW]  = AW'(63);
            ag_wdata[i*DW +: DW] = 8'hEE;
        end
        @(negedge clk);
        chk(ag_ready == 4'h0, "R3 ready stays low", int'(ag_ready), 0);
        chk(n_log == 0, "R2 host starves lanes", n_log, 0);
        ag_valid = '0;
        host_req = 1'b0;
        logging = 1'b1;
        repeat (22) @(negedge clk);
        logging = 1'b0;
        chk(n_log == 16, "R3 only DEPTH words per lane served", n_log, 16);
        for (int j = 0; j < 16; j++) begin
            int e;
            e = (j % 4) * 16 + (j / 4) + 1;
            chk(acc_log[j] == e, "R6 round-robin order", acc_log[j], e);
        end
        chk(ag_ready == 4'hF, "R3 ready restored", int'(ag_ready), 15);
        for (int k = 0; k < DEP; k++) begin
            for (int i = 1; i <= 2; i++) begin
                int a;
                a = i * 16 + k + 1;
                chk(md[a] == DW'(8'h40 + i * 8 + k), "R4 lane write data",
                    int'(md[a]), 8'h40 + i * 8 + k);
            end
            chk(rq[0][k] == f(k + 1), "R5 lane0 read order", int'(rq[0][k]), int'(f(k + 1)));
            chk(rq[3][k] == f(49 + k), "R5 lane3 read order", int'(rq[3][k]), int'(f(49 + k)));
        end
        chk(rn[0] == 4 && rn[3] == 4 && rn[1] == 0 && rn[2] == 0, "R5 return counts",
            rn[0] + rn[3] * 16 + rn[1] * 256, 4 + 64);

        // R9 R10: parity errors on the lane path and host path
        mp[60] = ~mp[60];
        mp[37] = ~mp[37];
        ag_valid = 4'b1000;
        ag_addr[3*AW +: AW] = AW'(60);
        @(negedge clk);
        ag_valid = '0;
        repeat (6) @(negedge clk);
        chk(par_err == 1'b1, "R9 stale read flagged", int'(par_err), 1);
        chk(par_err_addr == AW'(60), "R9 error address", int'(par_err_addr), 60);
        host_read(37, f(37), "R9 host read of bad word");
        chk(par_err_addr == AW'(60), "R9 first address held", int'(par_err_addr), 60);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(par_err == 1'b0, "R10 clear", int'(par_err), 0);
        host_read(37, f(37), "R9 host read after clear");
        chk(par_err == 1'b1 && par_err_addr == AW'(37), "R9 new address",
            int'(par_err_addr), 37);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(par_err == 1'b0, "R10 clear again", int'(par_err), 0);

        // R11: parity disabled
        parity_en = 1'b0;
        mp[5] = 1'b1;
        host_write(5, 8'h3C);
        repeat (2) @(negedge clk);
        chk(md[5] == 8'h3C, "R11 data still written", int'(md[5]), 8'h3C);
        chk(mp[5] == 1'b1, "R11 parity bit untouched", int'(mp[5]), 1);
        host_read(5, 8'h3C, "R11 read");
        chk(par_err == 1'b0, "R11 no error", int'(par_err), 0);
        host_read(60, md[60], "R11 read bad word");
        chk(par_err == 1'b0, "R11 no error on mismatch", int'(par_err), 0);
        parity_en = 1'b1;

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule